// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog counter controlled through four small registers: control/status, count, timeout limit and refresh window. Software keeps the system alive by writing an ordered pair of 16-bit key words to the count address, which restarts the count. A second key pair opens a short unlocked interval in which configuration may be rewritten. The control/status register reports whether the block is currently unlocked and whether the last reconfiguration took effect. If the count reaches the limit while counting is enabled, the block raises a timeout interrupt flag and a sticky reset request.

The count advances on one of four tick-enable inputs, chosen by a two-bit field, so a fast bus-rate tick or a slow external tick can pace it. An optional refresh window turns an early refresh into a fault. Register writes use a single-cycle write strobe. Reads are combinational from a separate read address.

Top module: `kwdt_top`

## Requirements
- R1: After reset the control/status register reads 16'h0020 (update-allowed bit 5 set, everything else clear). The count reads 0, the limit reads DEF_LIMIT and the window reads 0. `irq` and `rst_req` are low.
- R2: Writing 16'hA602 and then 16'hB480 to address 1 (count) is a refresh. The count is 0 from the clock edge that captures the second word.
- R3: Writing 16'hC520 and then 16'hD928 to address 1 sets status bit 11 (unlocked) from the edge that captures the second word.
- R4: The second word of a key pair is accepted only 1 to PAIR_GAP cycles after the first. A later word is ignored. A wrong second word ends the sequence with no effect.
- R5: The unlocked state ends after UNLOCK_CYC cycles, or at the edge of any accepted write to address 0 (control), whichever comes first.
- R6: Writes to addresses 0, 2 and 3 change configuration only while unlocked or while bit 5 is set. Otherwise their configuration fields are ignored.
- R7: Status bit 10 (reconfigured) is set by an accepted control write and cleared by a completed unlock sequence.
- R8: While control bit 7 is set, the count increases by one on each cycle where `tick_src[sel]` is high. `sel` is control bits 9:8. The count never increases past the limit. With bit 7 clear, the count holds.
- R9: One edge after the count is at or above the limit with bit 7 set, `irq` (status bit 14) and `rst_req` are high.
- R10: Writing 1 to control bit 14 clears `irq` at any time, whatever the lock state. A coincident expiry wins and keeps it set.
- R11: With a nonzero window, a refresh completed while the count is below the window raises `rst_req`. With window 0, no refresh raises it.
- R12: `rst_req` stays high once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | Write register address (0 control, 1 count, 2 limit, 3 window) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | DATA_W | Combinational read data |
| tick_src | input | 4 | Count tick enables, one per selectable source |
| irq | output | 1 | Timeout interrupt flag |
| rst_req | output | 1 | Sticky reset request |

## Verification
The bench builds the block with DEF_LIMIT of 40 and UNLOCK_CYC of 32, and keeps PAIR_GAP at 16 and the 16-bit widths. The short limit lets expiry, flag clearing and re-expiry happen within a few dozen cycles. The short unlock interval puts its exact last cycle within easy reach. With the default gap, key pairs can be tested exactly at the 16-cycle acceptance edge and one cycle past it, and these cases sit beside early-refresh window faults and lock-protected writes.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
   localparam int unsigned SEL_W   = 2;
   localparam int unsigned NUM_SRC = 1 << SEL_W;

   localparam logic [1:0] A_CTRL   = 2'd0;
   localparam logic [1:0] A_COUNT  = 2'd1;
   localparam logic [1:0] A_LIMIT  = 2'd2;
   localparam logic [1:0] A_WINDOW = 2'd3;

   localparam int unsigned B_UPD  = 5;
   localparam int unsigned B_EN   = 7;
   localparam int unsigned B_SEL  = 8;
   localparam int unsigned B_DONE = 10;
   localparam int unsigned B_ULK  = 11;
   localparam int unsigned B_FLAG = 14;

   localparam logic [15:0] KEY_REF_A = 16'hA602;
   localparam logic [15:0] KEY_REF_B = 16'hB480;
   localparam logic [15:0] KEY_ULK_A = 16'hC520;
   localparam logic [15:0] KEY_ULK_B = 16'hD928;

   typedef enum logic [1:0] {
      KS_IDLE = 2'd0,
      KS_REF  = 2'd1,
      KS_ULK  = 2'd2
   } key_state_e;
endpackage

// File: rtl/kwdt_keydec.sv
module kwdt_keydec
   import kwdt_pkg::*;
#(
   parameter int unsigned PAIR_GAP = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        key_wr,
   input  logic [15:0] key_word,
   output logic        refresh_p,
   output logic        unlock_p
);
   localparam int unsigned GAP_W = $clog2(PAIR_GAP);
   localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(PAIR_GAP - 1);

   key_state_e       st_q, st_d;
   logic [GAP_W-1:0] gap_q, gap_d;

   always_comb begin
      st_d      = st_q;
      gap_d     = gap_q;
      refresh_p = 1'b0;
      unlock_p  = 1'b0;
      if (key_wr) begin
         unique case (st_q)
            KS_IDLE: begin
               gap_d = '0;
               if (key_word == KEY_REF_A)      st_d = KS_REF;
               else if (key_word == KEY_ULK_A) st_d = KS_ULK;
            end
            KS_REF: begin
               refresh_p = (key_word == KEY_REF_B);
               st_d      = KS_IDLE;
            end
            KS_ULK: begin
               unlock_p = (key_word == KEY_ULK_B);
               st_d     = KS_IDLE;
            end
            default: st_d = KS_IDLE;
         endcase
      end else if (st_q != KS_IDLE) begin
         if (gap_q == GAP_LAST) st_d = KS_IDLE;
         else                   gap_d = gap_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= KS_IDLE;
         gap_q <= '0;
      end else begin
         st_q  <= st_d;
         gap_q <= gap_d;
      end
   end
endmodule

// File: rtl/kwdt_cfg.sv
module kwdt_cfg
   import kwdt_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned UNLOCK_CYC = 128,
   parameter int unsigned DEF_LIMIT  = 5376
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              unlock_p,
   output logic              ctl_en,
   output logic              ctl_upd,
   output logic [SEL_W-1:0]  ctl_sel,
   output logic [CNT_W-1:0]  limit,
   output logic [CNT_W-1:0]  window,
   output logic              unlocked,
   output logic              recfg_done,
   output logic              flag_clr
);
   localparam int unsigned UL_W = $clog2(UNLOCK_CYC);
   localparam logic [UL_W-1:0] UL_LOAD = UL_W'(UNLOCK_CYC - 1);

   logic            cfg_ok;
   logic            wr_ctrl, wr_lim, wr_win;
   logic [UL_W-1:0] ul_left_q;

   assign cfg_ok   = unlocked | ctl_upd;
   assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
   assign wr_lim   = wr_en && (wr_addr == A_LIMIT)  && cfg_ok;
   assign wr_win   = wr_en && (wr_addr == A_WINDOW) && cfg_ok;
   assign flag_clr = wr_ctrl && wr_data[B_FLAG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en  <= 1'b0;
         ctl_upd <= 1'b1;
         ctl_sel <= '0;
      end else if (wr_ctrl && cfg_ok) begin
         ctl_en  <= wr_data[B_EN];
         ctl_upd <= wr_data[B_UPD];
         ctl_sel <= wr_data[B_SEL +: SEL_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit  <= CNT_W'(DEF_LIMIT);
         window <= '0;
      end else begin
         if (wr_lim) limit  <= wr_data[CNT_W-1:0];
         if (wr_win) window <= wr_data[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlocked   <= 1'b0;
         ul_left_q  <= '0;
         recfg_done <= 1'b0;
      end else if (unlock_p) begin
         unlocked   <= 1'b1;
         ul_left_q  <= UL_LOAD;
         recfg_done <= 1'b0;
      end else begin
         if (wr_ctrl && cfg_ok) recfg_done <= 1'b1;
         if (unlocked) begin
            if (wr_ctrl || ul_left_q == '0) unlocked <= 1'b0;
            else                            ul_left_q <= ul_left_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
   import kwdt_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter bit          WIN_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] tick_src,
   input  logic [SEL_W-1:0]   ctl_sel,
   input  logic               ctl_en,
   input  logic [CNT_W-1:0]   limit,
   input  logic [CNT_W-1:0]   window,
   input  logic               refresh_p,
   input  logic               flag_clr,
   output logic [CNT_W-1:0]   count,
   output logic               irq_flag,
   output logic               rst_req
);
   logic tick, expire, early;

   assign tick   = tick_src[ctl_sel];
   assign expire = ctl_en && (count >= limit);

   generate
      if (WIN_EN) begin : g_window
         assign early = refresh_p && (window != '0) && (count < window);
      end else begin : g_no_window
         assign early = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (refresh_p) begin
         count <= '0;
      end else if (ctl_en && tick && (count < limit)) begin
         count <= count + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_flag <= 1'b0;
         rst_req  <= 1'b0;
      end else begin
         if (expire)        irq_flag <= 1'b1;
         else if (flag_clr) irq_flag <= 1'b0;
         if (expire || early) rst_req <= 1'b1;
      end
   end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
   import kwdt_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned PAIR_GAP   = 16,
   parameter int unsigned UNLOCK_CYC = 128,
   parameter int unsigned DEF_LIMIT  = 5376,
   parameter bit          WIN_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [3:0]        tick_src,
   output logic              irq,
   output logic              rst_req
);
   generate
      if (DATA_W < 16)               begin : g_bad_data  $error("DATA_W must be at least 16"); end
      if (CNT_W > DATA_W)            begin : g_bad_cnt   $error("CNT_W must not exceed DATA_W"); end
      if (PAIR_GAP < 2)              begin : g_bad_gap   $error("PAIR_GAP must be at least 2"); end
      if (UNLOCK_CYC < 2)            begin : g_bad_ulk   $error("UNLOCK_CYC must be at least 2"); end
      if (DEF_LIMIT >= (1 << CNT_W)) begin : g_bad_lim   $error("DEF_LIMIT must fit CNT_W"); end
   endgenerate

   logic             refresh_p, unlock_p;
   logic             ctl_en, ctl_upd, unlocked, recfg_done, flag_clr;
   logic [SEL_W-1:0] ctl_sel;
   logic [CNT_W-1:0] limit, window, count;
   logic [DATA_W-1:0] status_word;

   kwdt_keydec #(.PAIR_GAP(PAIR_GAP)) u_keys (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_wr    (wr_en && (wr_addr == A_COUNT)),
      .key_word  (wr_data[15:0]),
      .refresh_p (refresh_p),
      .unlock_p  (unlock_p)
   );

   kwdt_cfg #(
      .DATA_W     (DATA_W),
      .CNT_W      (CNT_W),
      .UNLOCK_CYC (UNLOCK_CYC),
      .DEF_LIMIT  (DEF_LIMIT)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .unlock_p   (unlock_p),
      .ctl_en     (ctl_en),
      .ctl_upd    (ctl_upd),
      .ctl_sel    (ctl_sel),
      .limit      (limit),
      .window     (window),
      .unlocked   (unlocked),
      .recfg_done (recfg_done),
      .flag_clr   (flag_clr)
   );

   kwdt_core #(.CNT_W(CNT_W), .WIN_EN(WIN_EN)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_src  (tick_src),
      .ctl_sel   (ctl_sel),
      .ctl_en    (ctl_en),
      .limit     (limit),
      .window    (window),
      .refresh_p (refresh_p),
      .flag_clr  (flag_clr),
      .count     (count),
      .irq_flag  (irq),
      .rst_req   (rst_req)
   );

   always_comb begin
      status_word                 = '0;
      status_word[B_FLAG]         = irq;
      status_word[B_ULK]          = unlocked;
      status_word[B_DONE]         = recfg_done;
      status_word[B_SEL +: SEL_W] = ctl_sel;
      status_word[B_EN]           = ctl_en;
      status_word[B_UPD]          = ctl_upd;
   end

   always_comb begin
      unique case (rd_addr)
         A_CTRL:  rd_data = status_word;
         A_COUNT: rd_data = DATA_W'(count);
         A_LIMIT: rd_data = DATA_W'(limit);
         default: rd_data = DATA_W'(window);
      endcase
   end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
   import kwdt_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic             refresh_p,
   input logic             unlock_p,
   input logic             ctl_en,
   input logic             ctl_upd,
   input logic             unlocked,
   input logic             recfg_done,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] limit,
   input logic             irq,
   input logic             rst_req
);
   assert_refresh_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_p |=> (count == '0));

   assert_unlock_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(unlock_p));

   assert_locked_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_LIMIT && !unlocked && !ctl_upd) |=> $stable(limit));

   assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(recfg_done) |-> $past(wr_en && wr_addr == A_CTRL));

   assert_step_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !refresh_p |=> (count == $past(count) || count == $past(count) + 1'b1));

   assert_expire_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_en && count >= limit) |=> (irq && rst_req));

   assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> rst_req);
endmodule

bind kwdt_top kwdt_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .refresh_p  (refresh_p),
   .unlock_p   (unlock_p),
   .ctl_en     (ctl_en),
   .ctl_upd    (ctl_upd),
   .unlocked   (unlocked),
   .recfg_done (recfg_done),
   .count      (count),
   .limit      (limit),
   .irq        (irq),
   .rst_req    (rst_req)
);

// File: tb/kwdt_top_test.sv
`timescale 1ns/10ps
module kwdt_top_test;
   localparam int LIM0 = 40;
   localparam int ULK  = 32;
   localparam int GAP  = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic [1:0]  rd_addr = 2'd0;
   logic [15:0] rd_data;
   logic [3:0]  tick_src = 4'b0001;
   logic        irq, rst_req;

   int n_checks = 0;
   int n_fail = 0;

   kwdt_top #(
      .DATA_W(16), .CNT_W(16), .PAIR_GAP(GAP), .UNLOCK_CYC(ULK),
      .DEF_LIMIT(LIM0), .WIN_EN(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .tick_src(tick_src), .irq(irq), .rst_req(rst_req)
   );

   always #2.5 clk = ~clk;

   // behavioural reference model
   int m_ks = 0, m_gap = 0, m_cnt = 0, m_lim = LIM0, m_win = 0;
   int m_en = 0, m_upd = 1, m_sel = 0, m_flag = 0, m_rst = 0;
   int m_unl = 0, m_left = 0, m_done = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ks = 0; m_gap = 0; m_cnt = 0; m_lim = LIM0; m_win = 0;
         m_en = 0; m_upd = 1; m_sel = 0; m_flag = 0; m_rst = 0;
         m_unl = 0; m_left = 0; m_done = 0;
      end else begin
         int ks, gp, cnt, flag, rst, unl, left, done, en, upd, sel, lim, win;
         bit rf, uk, ok, wctl, expire;
         ks = m_ks; gp = m_gap; cnt = m_cnt; flag = m_flag; rst = m_rst;
         unl = m_unl; left = m_left; done = m_done; en = m_en; upd = m_upd;
         sel = m_sel; lim = m_lim; win = m_win;
         rf = 0; uk = 0;
         if (wr_en && wr_addr == 2'd1) begin
            if (m_ks == 0) begin
               gp = 0;
               if (wr_data == 16'hA602) ks = 1;
               else if (wr_data == 16'hC520) ks = 2;
            end else begin
               if (m_ks == 1) rf = (wr_data == 16'hB480);
               else           uk = (wr_data == 16'hD928);
               ks = 0;
            end
         end else if (m_ks != 0) begin
            if (m_gap == GAP - 1) ks = 0; else gp = m_gap + 1;
         end
         expire = (m_en != 0) && (m_cnt >= m_lim);
         if (rf) cnt = 0;
         else if (m_en != 0 && tick_src[m_sel] && m_cnt < m_lim) cnt = m_cnt + 1;
         wctl = wr_en && wr_addr == 2'd0;
         if (expire) flag = 1; else if (wctl && wr_data[14]) flag = 0;
         if (expire || (rf && m_win != 0 && m_cnt < m_win)) rst = 1;
         ok = (m_unl != 0) || (m_upd != 0);
         if (wctl && ok) begin
            en = wr_data[7]; upd = wr_data[5]; sel = wr_data[9:8]; done = 1;
         end
         if (wr_en && wr_addr == 2'd2 && ok) lim = wr_data;
         if (wr_en && wr_addr == 2'd3 && ok) win = wr_data;
         if (uk) begin
            unl = 1; left = ULK - 1; done = 0;
         end else if (m_unl != 0) begin
            if (wctl || m_left == 0) unl = 0; else left = m_left - 1;
         end
         m_ks = ks; m_gap = gp; m_cnt = cnt; m_flag = flag; m_rst = rst;
         m_unl = unl; m_left = left; m_done = done; m_en = en; m_upd = upd;
         m_sel = sel; m_lim = lim; m_win = win;
      end
   end

   function automatic int model_read(input logic [1:0] a);
      case (a)
         2'd0: return (m_flag << 14) | (m_unl << 11) | (m_done << 10) |
                      (m_sel << 8) | (m_en << 7) | (m_upd << 5);
         2'd1: return m_cnt;
         2'd2: return m_lim;
         default: return m_win;
      endcase
   endfunction

   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         n_checks++;
         if (irq !== m_flag[0]) begin
            n_fail++;
            $display("FAIL R9 model irq: got %0d expected %0d", irq, m_flag);
         end
         if (rst_req !== m_rst[0]) begin
            n_fail++;
            $display("FAIL R12 model rst_req: got %0d expected %0d", rst_req, m_rst);
         end
         if (int'(rd_data) != model_read(rd_addr)) begin
            n_fail++;
            $display("FAIL R8 model read addr %0d: got %0h expected %0h",
                     rd_addr, rd_data, model_read(rd_addr));
         end
      end
   end

   task automatic chk(input string name, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", name, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      rd_addr = a;
      #0.1;
      v = int'(rd_data);
   endtask

   task automatic rd_chk(input logic [1:0] a, input int exp, input string name);
      int v;
      rd(a, v);
      chk(name, v, exp);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
   endtask

   task automatic refresh();
      wr(2'd1, 16'hA602);
      wr(2'd1, 16'hB480);
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #500000;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      int a, v;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1: reset state
      rd_chk(2'd0, 16'h0020, "R1 ctrl after reset");
      rd_chk(2'd1, 0, "R1 count after reset");
      rd_chk(2'd2, LIM0, "R1 limit after reset");
      rd_chk(2'd3, 0, "R1 window after reset");
      chk("R1 irq after reset", int'(irq), 0);
      chk("R1 rst_req after reset", int'(rst_req), 0);

      // R8: enable on source 0
      wr(2'd0, 16'h00A0);
      rd(2'd1, a);
      idle(3);
      rd_chk(2'd1, a + 3, "R8 counting on bus tick");

      // R2: refresh pair
      refresh();
      rd_chk(2'd1, 0, "R2 refresh clears count");

      // R4: wrong second word
      rd(2'd1, a);
      wr(2'd1, 16'hA602);
      wr(2'd1, 16'h1234);
      wr(2'd1, 16'hB480);
      rd_chk(2'd1, a + 3, "R4 wrong second word discards");

      // R4: second word exactly PAIR_GAP cycles later
      wr(2'd1, 16'hA602);
      idle(GAP - 1);
      wr(2'd1, 16'hB480);
      rd_chk(2'd1, 0, "R4 second word at gap limit");

      // R4: one cycle too late
      rd(2'd1, a);
      wr(2'd1, 16'hA602);
      idle(GAP);
      wr(2'd1, 16'hB480);
      rd_chk(2'd1, a + GAP + 2, "R4 late second word ignored");
      chk("R11 window zero never faults", int'(rst_req), 0);

      // R8: source select
      wr(2'd0, 16'h02A0);
      rd(2'd1, a);
      idle(5);
      rd_chk(2'd1, a, "R8 unselected source ignored");
      tick_src = 4'b0101;
      idle(3);
      tick_src = 4'b0001;
      rd_chk(2'd1, a + 3, "R8 selected source counts");
      wr(2'd0, 16'h0020);
      rd(2'd1, a);
      idle(4);
      rd_chk(2'd1, a, "R8 disabled count holds");

      // R11 / R12: window
      do_reset();
      wr(2'd3, 16'd10);
      wr(2'd0, 16'h00A0);
      idle(15);
      refresh();
      chk("R11 refresh after window open", int'(rst_req), 0);
      refresh();
      chk("R11 early refresh faults", int'(rst_req), 1);
      idle(20);
      chk("R12 reset request sticky", int'(rst_req), 1);

      // R6 / R7 / R3 / R5: lock handling
      do_reset();
      wr(2'd0, 16'h0000);
      rd_chk(2'd0, 16'h0400, "R7 done after accepted ctrl write");
      wr(2'd2, 16'd5);
      rd_chk(2'd2, LIM0, "R6 locked limit write ignored");
      wr(2'd0, 16'h00A0);
      rd_chk(2'd0, 16'h0400, "R6 locked ctrl write ignored");
      wr(2'd1, 16'hC520);
      wr(2'd1, 16'hA602);
      rd_chk(2'd0, 16'h0400, "R4 wrong unlock word");
      wr(2'd1, 16'hC520);
      wr(2'd1, 16'hD928);
      rd_chk(2'd0, 16'h0800, "R3 unlocked and R7 done cleared");
      wr(2'd2, 16'd5);
      rd_chk(2'd2, 5, "R6 unlocked limit write");
      wr(2'd0, 16'h0080);
      rd_chk(2'd0, 16'h0480, "R5 ctrl write ends unlock");

      // R9 / R10: expiry and flag clear
      idle(8);
      chk("R9 irq on expiry", int'(irq), 1);
      chk("R9 rst_req on expiry", int'(rst_req), 1);
      rd_chk(2'd1, 5, "R8 count stops at limit");
      refresh();
      wr(2'd0, 16'h4000);
      chk("R10 flag cleared by write one", int'(irq), 0);
      chk("R12 rst_req still high", int'(rst_req), 1);
      rd_chk(2'd0, 16'h0480, "R6 locked ctrl fields kept");
      idle(8);
      chk("R9 irq on second expiry", int'(irq), 1);
      wr(2'd0, 16'h4000);
      chk("R10 expiry wins over clear", int'(irq), 1);

      // R5: unlock interval length
      wr(2'd1, 16'hC520);
      wr(2'd1, 16'hD928);
      rd(2'd0, v);
      chk("R3 unlocked bit set", (v >> 11) & 1, 1);
      chk("R7 done cleared by unlock", (v >> 10) & 1, 0);
      idle(ULK - 1);
      rd(2'd0, v);
      chk("R5 unlocked on last cycle", (v >> 11) & 1, 1);
      idle(1);
      rd(2'd0, v);
      chk("R5 unlock expired", (v >> 11) & 1, 0);

      idle(2);
      finish_run();
   end
endmodule